// File: doc/BRIEF.md
# Timestep-Synchronized Spiking Neuron Core

This block advances a population of leaky integrate-and-fire neurons in discrete timesteps. Between barriers it accepts spike events on an input port. Each event names a source. Every worker reads that source's row in its local synaptic memory, which holds one weight and one delay per target neuron. The worker then adds each weight into the target's circular delay ring, in the slot that belongs to the current step plus the delay.

A barrier request starts the neuron update. All workers run in parallel, and each walks through its contiguous group of neurons one per cycle. A neuron whose membrane reaches threshold is reset and yields a spike packet. A round-robin merge collects the workers' spike packets into one output stream. Once every spike packet for the step has been taken, the core sends a sync packet, rotates its rings and accepts input for the next step.

Membrane, weights and ring slots are 32-bit signed fixed point with 20 fraction bits (12 integer bits). Every sum saturates at the signed limits.

Top module: `lif_step_core`

## Requirements
- R1: After reset the core presents no output and `in_ready` is high. The first sync packet carries timestep 0.
- R2: An accepted event from source s adds weight(s,n) to the ring of every neuron n, in slot (current step + delay(s,n)) mod DEPTH. A delay of 0 means the current step. A delay of k means k steps later.
- R3: Ring accumulation and membrane update saturate to 0x7FFFFFFF or 0x80000000 instead of wrapping.
- R4: At each step every neuron computes v' = v - (v >>> LEAK_SHIFT) + slot. If v' >= THRESH (signed) it fires and v becomes 0. Otherwise v becomes v'.
- R5: After a neuron's update its current slot reads zero. The ring pointer advances by one (mod DEPTH) when the sync packet is taken.
- R6: A spike packet has `out_sync`=0, and `out_data` is the global neuron index (worker * NPW + local index).
- R7: The sync packet (`out_sync`=1, `out_data`=timestep count mod 2^OUT_W) follows every spike packet of its step. Timesteps increase by one per sync. No packet appears in the cycle after a sync handshake.
- R8: `in_ready` stays low from the accepted barrier request until the sync packet is taken. A barrier request is accepted only while the core is idle.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_sync` and `out_data` hold.
- R10: Each neuron that fires in a step produces exactly one spike packet in that step. At most one worker is granted per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write one synaptic memory entry |
| cfg_src | input | $clog2(N_SRC) | Source row of the entry |
| cfg_nrn | input | IDX_W | Global target neuron of the entry |
| cfg_weight | input | 32 | Signed Q12.20 weight |
| cfg_delay | input | $clog2(DEPTH) | Delay in steps |
| in_valid | input | 1 | Spike event present |
| in_src | input | $clog2(N_SRC) | Source index of the event |
| in_ready | output | 1 | Event accepted this cycle when high with in_valid |
| step_go | input | 1 | Barrier request: update the current step |
| out_valid | output | 1 | Output packet present |
| out_sync | output | 1 | 1 = sync packet, 0 = spike packet |
| out_data | output | OUT_W | Neuron index or timestep number |
| out_ready | input | 1 | Consumer takes the packet |

## Verification
The bound checker watches the packet protocol on every cycle. It checks that a stalled output holds and that input is refused while spike or sync packets are pending. It also checks that spike indices stay in range, that timestep numbers count up, that the output is quiet right after a sync, and that at most one worker is granted at a time. The numeric behaviour can only be shown by the bench's scenarios. That covers the placement of delayed weights in the ring, leak, threshold and reset, saturation on oversized weights, and slot clearing. The bench compares each step's set of firing neurons against an independent fixed-point model over several hundred steps, with and without output back-pressure.

// File: rtl/lif_core_pkg.sv
package lif_core_pkg;
   typedef logic signed [31:0] fx_t;

   typedef enum logic [1:0] {W_IDLE, W_FAN, W_UPD} wk_state_t;
   typedef enum logic [1:0] {C_RUN, C_STEP, C_SYNC} core_state_t;

   // signed add clamped to the 32-bit range
   function automatic fx_t fx_sat_add(fx_t a, fx_t b);
      logic signed [32:0] s;
      s = {a[31], a} + {b[31], b};
      if (s[32] != s[31]) return s[32] ? 32'sh8000_0000 : 32'sh7FFF_FFFF;
      return s[31:0];
   endfunction
endpackage

// File: rtl/lif_worker.sv
module lif_worker
   import lif_core_pkg::*;
#(
   parameter int   NPW        = 8,
   parameter int   N_SRC      = 8,
   parameter int   DEPTH      = 4,
   parameter int   LEAK_SHIFT = 3,
   parameter fx_t  THRESH     = 32'sh0010_0000,
   parameter int   IDX_W      = 5,
   parameter int   WORKER_ID  = 0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ev_go,
   input  logic [$clog2(N_SRC)-1:0]   ev_src,
   input  logic                       upd_go,
   input  logic [$clog2(DEPTH)-1:0]   rd_ptr,
   input  logic                       cfg_we,
   input  logic [$clog2(N_SRC)-1:0]   cfg_src,
   input  logic [$clog2(NPW)-1:0]     cfg_lidx,
   input  fx_t                        cfg_w,
   input  logic [$clog2(DEPTH)-1:0]   cfg_d,
   input  logic                       take,
   output logic                       busy,
   output logic                       sp_valid,
   output logic [IDX_W-1:0]           sp_idx
);
   localparam int LW = $clog2(NPW);
   localparam int SW = $clog2(N_SRC);
   localparam int DW = $clog2(DEPTH);

   fx_t             wmem [N_SRC*NPW];
   logic [DW-1:0]   dmem [N_SRC*NPW];
   fx_t             ring [NPW*DEPTH];
   fx_t             vmem [NPW];

   wk_state_t       state;
   logic [LW-1:0]   cnt;
   logic [SW-1:0]   src_q;

   logic [SW+LW-1:0] waddr;
   logic [DW-1:0]    fan_slot;
   logic [LW+DW-1:0] fan_ra, upd_ra;
   fx_t              v_leak, v_next;

   always_comb begin
      waddr    = {src_q, cnt};
      fan_slot = rd_ptr + dmem[waddr];
      fan_ra   = {cnt, fan_slot};
      upd_ra   = {cnt, rd_ptr};
      v_leak   = vmem[cnt] - (vmem[cnt] >>> LEAK_SHIFT);
      v_next   = fx_sat_add(v_leak, ring[upd_ra]);
   end

   assign busy = (state != W_IDLE);

   always_ff @(posedge clk) begin
      if (cfg_we) begin
         wmem[{cfg_src, cfg_lidx}] <= cfg_w;
         dmem[{cfg_src, cfg_lidx}] <= cfg_d;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= W_IDLE;
         cnt      <= '0;
         src_q    <= '0;
         sp_valid <= 1'b0;
         sp_idx   <= '0;
         for (int i = 0; i < NPW*DEPTH; i++) ring[i] <= '0;
         for (int i = 0; i < NPW; i++) vmem[i] <= '0;
      end else begin
         if (take) sp_valid <= 1'b0;
         case (state)
            W_IDLE: begin
               cnt <= '0;
               if (ev_go) begin
                  src_q <= ev_src;
                  state <= W_FAN;
               end else if (upd_go) begin
                  state <= W_UPD;
               end
            end
            W_FAN: begin
               ring[fan_ra] <= fx_sat_add(ring[fan_ra], wmem[waddr]);
               cnt <= cnt + 1'b1;
               if (cnt == LW'(NPW-1)) state <= W_IDLE;
            end
            W_UPD: begin
               if (!sp_valid || take) begin
                  ring[upd_ra] <= '0;
                  if (v_next >= THRESH) begin
                     vmem[cnt] <= '0;
                     sp_valid  <= 1'b1;
                     sp_idx    <= IDX_W'(WORKER_ID*NPW) + IDX_W'(cnt);
                  end else begin
                     vmem[cnt] <= v_next;
                  end
                  cnt <= cnt + 1'b1;
                  if (cnt == LW'(NPW-1)) state <= W_IDLE;
               end
            end
            default: state <= W_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rr_merge.sv
module rr_merge #(
   parameter int N     = 4,
   parameter int IDX_W = 5
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N-1:0]              req,
   input  logic [N-1:0][IDX_W-1:0]   idx,
   output logic [N-1:0]              take,
   output logic                      o_valid,
   output logic [IDX_W-1:0]          o_idx,
   input  logic                      o_ready
);
   localparam int PW = (N > 1) ? $clog2(N) : 1;

   logic [PW-1:0] last, sel;
   logic          found, free;

   assign free = !o_valid || o_ready;

   always_comb begin
      found = 1'b0;
      sel   = '0;
      take  = '0;
      for (int k = 1; k <= N; k++) begin
         automatic int j = (int'(last) + k) % N;
         if (!found && req[j]) begin
            found = 1'b1;
            sel   = PW'(j);
         end
      end
      if (free && found) take[sel] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         o_valid <= 1'b0;
         o_idx   <= '0;
         last    <= PW'(N-1);
      end else if (free) begin
         o_valid <= found;
         if (found) begin
            o_idx <= idx[sel];
            last  <= sel;
         end
      end
   end
endmodule

// File: rtl/lif_step_core.sv
module lif_step_core
   import lif_core_pkg::*;
#(
   parameter int  N_WORKERS  = 4,
   parameter int  NPW        = 8,
   parameter int  N_SRC      = 8,
   parameter int  DEPTH      = 4,
   parameter int  LEAK_SHIFT = 3,
   parameter fx_t THRESH     = 32'sh0010_0000,
   parameter int  OUT_W      = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cfg_we,
   input  logic [$clog2(N_SRC)-1:0]    cfg_src,
   input  logic [$clog2(N_WORKERS*NPW)-1:0] cfg_nrn,
   input  logic [31:0]                 cfg_weight,
   input  logic [$clog2(DEPTH)-1:0]    cfg_delay,
   input  logic                        in_valid,
   input  logic [$clog2(N_SRC)-1:0]    in_src,
   output logic                        in_ready,
   input  logic                        step_go,
   output logic                        out_valid,
   output logic                        out_sync,
   output logic [OUT_W-1:0]            out_data,
   input  logic                        out_ready
);
   localparam int N_NEUR = N_WORKERS * NPW;
   localparam int IDX_W  = $clog2(N_NEUR);
   localparam int LW     = $clog2(NPW);
   localparam int DW     = $clog2(DEPTH);

   if (NPW < 2 || (NPW & (NPW-1)) != 0) begin : g_bad_npw
      $error("NPW must be a power of two >= 2");
   end
   if (N_WORKERS < 2 || (N_WORKERS & (N_WORKERS-1)) != 0) begin : g_bad_nw
      $error("N_WORKERS must be a power of two >= 2");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH-1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two >= 2");
   end
   if (N_SRC < 2 || (N_SRC & (N_SRC-1)) != 0) begin : g_bad_src
      $error("N_SRC must be a power of two >= 2");
   end
   if (OUT_W < IDX_W) begin : g_bad_out
      $error("OUT_W too narrow for neuron index");
   end

   core_state_t                     cstate;
   logic [DW-1:0]                   rd_ptr;
   logic [OUT_W-1:0]                ts;
   logic [N_WORKERS-1:0]            wk_busy, wk_sp_valid, wk_take;
   logic [N_WORKERS-1:0][IDX_W-1:0] wk_sp_idx;
   logic                            m_valid;
   logic [IDX_W-1:0]                m_idx;
   logic                            idle, ev_go, upd_go;

   assign idle     = (cstate == C_RUN) && !(|wk_busy);
   assign in_ready = idle && !step_go;
   assign ev_go    = in_valid && in_ready;
   assign upd_go   = idle && step_go;

   for (genvar w = 0; w < N_WORKERS; w++) begin : g_wk
      logic wk_cfg_we;
      assign wk_cfg_we = cfg_we && (cfg_nrn[IDX_W-1:LW] == (IDX_W-LW)'(w));
      lif_worker #(
         .NPW(NPW), .N_SRC(N_SRC), .DEPTH(DEPTH), .LEAK_SHIFT(LEAK_SHIFT),
         .THRESH(THRESH), .IDX_W(IDX_W), .WORKER_ID(w)
      ) u_wk (
         .clk(clk), .rst_n(rst_n),
         .ev_go(ev_go), .ev_src(in_src),
         .upd_go(upd_go), .rd_ptr(rd_ptr),
         .cfg_we(wk_cfg_we), .cfg_src(cfg_src), .cfg_lidx(cfg_nrn[LW-1:0]),
         .cfg_w(fx_t'(cfg_weight)), .cfg_d(cfg_delay),
         .take(wk_take[w]), .busy(wk_busy[w]),
         .sp_valid(wk_sp_valid[w]), .sp_idx(wk_sp_idx[w])
      );
   end

   rr_merge #(.N(N_WORKERS), .IDX_W(IDX_W)) u_merge (
      .clk(clk), .rst_n(rst_n),
      .req(wk_sp_valid), .idx(wk_sp_idx), .take(wk_take),
      .o_valid(m_valid), .o_idx(m_idx),
      .o_ready(out_ready && (cstate != C_SYNC))
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cstate <= C_RUN;
         rd_ptr <= '0;
         ts     <= '0;
      end else begin
         case (cstate)
            C_RUN:  if (upd_go) cstate <= C_STEP;
            C_STEP: if (!(|wk_busy) && !(|wk_sp_valid) && !m_valid) cstate <= C_SYNC;
            C_SYNC: if (out_ready) begin
               rd_ptr <= rd_ptr + 1'b1;
               ts     <= ts + 1'b1;
               cstate <= C_RUN;
            end
            default: cstate <= C_RUN;
         endcase
      end
   end

   assign out_sync  = (cstate == C_SYNC);
   assign out_valid = m_valid || out_sync;
   assign out_data  = out_sync ? ts : OUT_W'(m_idx);
endmodule

// File: rtl/lif_core_chk.sv
module lif_core_chk #(
   parameter int N_WORKERS = 4,
   parameter int OUT_W     = 16,
   parameter int N_NEUR    = 32
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_ready,
   input logic                 out_valid,
   input logic                 out_sync,
   input logic [OUT_W-1:0]     out_data,
   input logic                 out_ready,
   input logic [N_WORKERS-1:0] wk_take
);
   logic [OUT_W-1:0] exp_ts;

   always_ff @(posedge clk) begin
      if (!rst_n) exp_ts <= '0;
      else if (out_valid && out_sync && out_ready) exp_ts <= exp_ts + 1'b1;
   end

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sync));

   p_spike_blocks_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);

   p_idx_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_sync |-> (32'(out_data) < N_NEUR));

   p_ts_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_sync |-> out_data == exp_ts);

   p_quiet_after_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_sync && out_ready |=> !out_valid);

   p_one_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wk_take));
endmodule

bind lif_step_core lif_core_chk #(
   .N_WORKERS(N_WORKERS), .OUT_W(OUT_W), .N_NEUR(N_NEUR)
) u_chk (.*);

// File: tb/lif_step_core_bench.sv
module lif_step_core_bench;
   localparam int NN = 32;
   localparam int NS = 8;
   localparam int DP = 4;
   localparam int STEPS = 320;
   localparam logic [7:0] STIM [16] = '{
      8'h00, 8'h81, 8'h03, 8'h00, 8'h1C, 8'hC0, 8'h25, 8'h00,
      8'h7F, 8'h42, 8'h00, 8'h90, 8'h0F, 8'h88, 8'h00, 8'hFF};

   logic clk = 0, rst_n = 0;
   logic cfg_we = 0;
   logic [2:0] cfg_src = 0;
   logic [4:0] cfg_nrn = 0;
   logic [31:0] cfg_weight = 0;
   logic [1:0] cfg_delay = 0;
   logic in_valid = 0;
   logic [2:0] in_src = 0;
   logic in_ready;
   logic step_go = 0;
   logic out_valid, out_sync, out_ready = 0;
   logic [15:0] out_data;

   int checks = 0, fails = 0, cyc = 0;
   logic signed [31:0] mv [NN];
   logic signed [31:0] mring [NN][DP];
   int mrd = 0;
   logic [7:0] lfsr = 8'h5A;

   always #10 clk = ~clk;

   lif_step_core u_lif_step_core (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_src(cfg_src), .cfg_nrn(cfg_nrn),
      .cfg_weight(cfg_weight), .cfg_delay(cfg_delay), .in_valid(in_valid), .in_src(in_src),
      .in_ready(in_ready), .step_go(step_go), .out_valid(out_valid), .out_sync(out_sync),
      .out_data(out_data), .out_ready(out_ready));

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         fails++;
         $display("FAIL watchdog R7: actual=no sync, expected=sync before cycle limit");
         summary();
         $finish;
      end
   end

   function automatic logic signed [31:0] wt(int s, int n);
      if (s == 7 && n < 2) return 32'sh7FF0_0000;
      if (s == 6 && n == 2) return 32'sh8010_0000;
      return 32'(((s*7 + n*3) % 11) - 3) * 32'sd157286;
   endfunction

   function automatic int dl(int s, int n);
      return (s + n) % DP;
   endfunction

   function automatic logic signed [31:0] bsat(logic signed [31:0] a, logic signed [31:0] b);
      longint s;
      s = longint'(a) + longint'(b);
      if (s > 64'sd2147483647) return 32'sh7FFF_FFFF;
      if (s < -64'sd2147483648) return 32'sh8000_0000;
      return 32'(s);
   endfunction

   task automatic check(bit ok, string req, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_step(int t, logic [7:0] mask, bit bp);
      logic [31:0] expm = 0, got = 0;
      bit dup = 0, done = 0, stall = 0, first = 1;
      logic [15:0] hold_d = 0;
      logic hold_s = 0;
      logic signed [31:0] vl, vn;
      // model (R2 R3 R4 R5)
      for (int s = 0; s < NS; s++)
         if (mask[s])
            for (int n = 0; n < NN; n++)
               mring[n][(mrd + dl(s, n)) % DP] = bsat(mring[n][(mrd + dl(s, n)) % DP], wt(s, n));
      for (int n = 0; n < NN; n++) begin
         vl = mv[n] - (mv[n] >>> 3);
         vn = bsat(vl, mring[n][mrd]);
         mring[n][mrd] = 0;
         if (vn >= 32'sh0010_0000) begin
            mv[n] = 0;
            expm[n] = 1'b1;
         end else mv[n] = vn;
      end
      mrd = (mrd + 1) % DP;
      // DUT
      for (int s = 0; s < NS; s++) begin
         if (mask[s]) begin
            @(negedge clk); in_valid = 1; in_src = 3'(s);
            while (!in_ready) @(negedge clk);
            @(negedge clk); in_valid = 0;
         end
      end
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      step_go = 1;
      @(negedge clk); step_go = 0;
      while (!done) begin
         #1;
         if (first) begin
            check(in_ready == 0, "R8", longint'(in_ready), 0);
            first = 0;
         end
         if (stall) begin
            check(out_valid && out_data == hold_d && out_sync == hold_s, "R9",
                  longint'(out_data), longint'(hold_d));
         end
         stall = out_valid && !out_ready;
         hold_d = out_data; hold_s = out_sync;
         if (out_valid && out_ready) begin
            if (out_sync) begin
               check(out_data == 16'(t), t == 0 ? "R1 R7" : "R7", longint'(out_data), longint'(t));
               done = 1;
            end else if (out_data < 16'(NN)) begin
               if (got[out_data[4:0]]) dup = 1;
               got[out_data[4:0]] = 1'b1;
            end else dup = 1;
         end
         @(negedge clk);
         out_ready = bp ? lfsr[0] : 1'b1;
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      end
      check(!dup, "R6 R10", longint'(dup), 0);
      check(got == expm, "R2 R3 R4 R5", longint'(got), longint'(expm));
   endtask

   initial begin
      for (int n = 0; n < NN; n++) begin
         mv[n] = 0;
         for (int d = 0; d < DP; d++) mring[n][d] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check(out_valid == 0, "R1", longint'(out_valid), 0);
      check(in_ready == 1, "R1", longint'(in_ready), 1);
      for (int s = 0; s < NS; s++)
         for (int n = 0; n < NN; n++) begin
            @(negedge clk);
            cfg_we = 1; cfg_src = 3'(s); cfg_nrn = 5'(n);
            cfg_weight = wt(s, n); cfg_delay = 2'(dl(s, n));
         end
      @(negedge clk); cfg_we = 0;
      out_ready = 1;
      for (int t = 0; t < STEPS; t++) begin
         logic [7:0] m;
         m = STIM[t % 16];
         m = (m << ((t / 16) % 8)) | (m >> (8 - (t / 16) % 8));
         run_step(t, m, ((t / 8) % 2) == 1);
      end
      // directed: a quiet step after activity must drain remaining delayed input only
      run_step(STEPS, 8'h00, 1'b0);
      @(negedge clk);
      check(out_valid == 0, "R7", longint'(out_valid), 0);
      summary();
      $finish;
   end
endmodule